// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a system-on-chip. It counts ticks from a slow free-running oscillator whose rate does not depend on the system clock. If software does not restart the count in time, the watchdog raises a one-cycle reset request. The oscillator arrives as a plain level signal. It is synchronised into the system clock domain, and each rising edge becomes a one-cycle count enable. The counter is `CNT_W` bits wide. A 3-bit timeout select chooses a limit of `2^(BASE_EXP+code)` ticks. With the default `BASE_EXP` of 9 and a 250 kHz oscillator, codes 0 to 7 give timeouts from 2.048 ms to 262.144 ms.

Software reaches the watchdog through a plain register write port. Each write selects one of three registers: control, key or status. The control register holds the enable bit, a restart bit and the timeout select. The control register cannot be written until the key register has received a two-byte opening sequence. The same two bytes in the reverse order lock it again. A status flag records that the most recent reset came from the watchdog.

The watchdog's own reset returns the control register and the key lock to their reset state and sets the flag. Only the hardware reset input or a software clear will zero the flag. The chip reset tree that acts on the request lies outside this block. That tree must not drive `rst_n` from `wdt_rst_req`. The port is write-only with no handshake: every cycle with `wr_en` high is one write, and the block never stalls it.

Top module: `keyed_wdog`

## Requirements
- R1: While `rst_n` is low and after it is released, `ctrl_rdata` reads 0x00, `ctrl_open` is 0, `wdt_flag` is 0 and `wdt_rst_req` is 0.
- R2: Register select codes are: control 0, key 1, status 2. A write to the control register while `ctrl_open` is 0 is ignored. Key byte 0x1E followed by key byte 0xE1 sets `ctrl_open` to 1 in the cycle after the second write.
- R3: While open, key byte 0xE1 followed by key byte 0x1E clears `ctrl_open`. Any later control write is then ignored.
- R4: A key byte that does not continue the sequence in progress returns the detector to its idle state, and the lock state stays as it was. Writes to other registers do not disturb the sequence.
- R5: The control byte holds the enable at bit 7, restart at bit 5 and timeout select at bits 2..0. On readback, bit 5 and all unused bits read 0.
- R6: With the enable at 1, a reset request is raised after exactly `2^(BASE_EXP+select)` synchronised ticks counted from the moment of enabling or restarting.
- R7: An accepted control write with bit 5 set zeroes the counter at that clock edge. Counting then starts again from zero, so timely restarts prevent any request.
- R8: While the enable is 0, the counter stays at zero and no reset request is ever raised.
- R9: On timeout, `wdt_rst_req` is high for exactly one cycle. In that same cycle the control register reads 0x00 and `ctrl_open` is 0, even when the timeout happens while locked.
- R10: `wdt_flag` goes to 1 together with the reset request and stays 1 through later watchdog resets. It is cleared only by `rst_n` or by a status write with bit 7 at 0. A status write with bit 7 at 1 has no effect.
- R11: The counter advances once per rising edge of `osc_tick`, however long the oscillator stays high. The edge passes through a two-flop synchroniser before it is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| osc_tick | input | 1 | Level from the slow independent oscillator |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Register select: 0 control, 1 key, 2 status |
| wr_data | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register readback |
| ctrl_open | output | 1 | Control register currently writable |
| wdt_flag | output | 1 | Last reset came from the watchdog |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with `CNT_W` = 9 and `BASE_EXP` = 2. This keeps the full set of eight timeout codes, so every code from 4 ticks up to 512 ticks can overflow within a few thousand cycles. Code 7 then needs every counter bit, so the widest tap and the full compare are exercised. The oscillator half-period is changed during the run. A long high phase shows that a tick is counted once per edge rather than once per cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  // register select codes on the write port
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_KEY  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  // control byte field positions
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_CLR_BIT = 5;
  localparam int STAT_FLAG_BIT = 7;

  typedef enum logic [1:0] {
    KS_SHUT       = 2'd0,
    KS_SHUT_ARMED = 2'd1,
    KS_OPEN       = 2'd2,
    KS_OPEN_ARMED = 2'd3
  } key_state_e;

endpackage

// File: rtl/kwd_tick_sync.sv
module kwd_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic tick_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              seen_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= osc_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], osc_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= chain_q[LAST];
  end

  // one enable pulse per synchronised rising edge
  assign tick_o = chain_q[LAST] & ~seen_q;
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
#(
  parameter logic [7:0] OPEN_A  = 8'h1E,
  parameter logic [7:0] OPEN_B  = 8'hE1,
  parameter logic [7:0] CLOSE_A = 8'hE1,
  parameter logic [7:0] CLOSE_B = 8'h1E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       wd_fire,
  output logic       open_o
);
  key_state_e st_q, st_d;

  always_comb begin
    case (st_q)
      KS_SHUT:       st_d = (key_byte == OPEN_A)  ? KS_SHUT_ARMED : KS_SHUT;
      KS_SHUT_ARMED: st_d = (key_byte == OPEN_B)  ? KS_OPEN       : KS_SHUT;
      KS_OPEN:       st_d = (key_byte == CLOSE_A) ? KS_OPEN_ARMED : KS_OPEN;
      KS_OPEN_ARMED: st_d = (key_byte == CLOSE_B) ? KS_SHUT       : KS_OPEN;
      default:       st_d = KS_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= KS_SHUT;
    else if (wd_fire) st_q <= KS_SHUT;
    else if (key_wr)  st_q <= st_d;
  end

  assign open_o = (st_q == KS_OPEN) || (st_q == KS_OPEN_ARMED);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W    = 16,
  parameter int BASE_EXP = 9,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             fire
);
  localparam int CODES = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_tbl [CODES];

  // terminal count per select code: 2^(BASE_EXP+code) - 1
  generate
    for (genvar g = 0; g < CODES; g++) begin : g_lim
      assign lim_tbl[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
    end
  endgenerate

  assign fire = tick & run & ~restart & (cnt_q >= lim_tbl[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!run || restart || fire) cnt_q <= '0;
    else if (tick)                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int         CNT_W       = 16,
  parameter int         BASE_EXP    = 9,
  parameter int         SEL_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] KEY_A       = 8'h1E,
  parameter logic [7:0] KEY_B       = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_rdata,
  output logic       ctrl_open,
  output logic       wdt_flag,
  output logic       wdt_rst_req
);
  logic             tick;
  logic             fire;
  logic             ctl_wr, key_wr, st_wr, restart;
  logic             en_q, flag_q, req_q;
  logic [SEL_W-1:0] sel_q;

  assign ctl_wr  = wr_en && (wr_sel == SEL_CTRL) && ctrl_open;
  assign key_wr  = wr_en && (wr_sel == SEL_KEY);
  assign st_wr   = wr_en && (wr_sel == SEL_STAT);
  assign restart = ctl_wr && wr_data[CTL_CLR_BIT];

  kwd_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_i  (osc_tick),
    .tick_o (tick)
  );

  kwd_key_seq #(
    .OPEN_A  (KEY_A),
    .OPEN_B  (KEY_B),
    .CLOSE_A (KEY_B),
    .CLOSE_B (KEY_A)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (wr_data),
    .wd_fire  (fire),
    .open_o   (ctrl_open)
  );

  kwd_counter #(
    .CNT_W    (CNT_W),
    .BASE_EXP (BASE_EXP),
    .SEL_W    (SEL_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (en_q),
    .restart (restart),
    .sel     (sel_q),
    .fire    (fire)
  );

  // control register; a timeout acts as the watchdog's own reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (fire) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (ctl_wr) begin
      en_q  <= wr_data[CTL_EN_BIT];
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  // cause flag survives the watchdog reset, only hardware reset or software clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 flag_q <= 1'b0;
    else if (fire)                              flag_q <= 1'b1;
    else if (st_wr && !wr_data[STAT_FLAG_BIT])  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fire;
  end

  always_comb begin
    ctrl_rdata             = '0;
    ctrl_rdata[CTL_EN_BIT] = en_q;
    ctrl_rdata[SEL_W-1:0]  = sel_q;
  end

  assign wdt_flag    = flag_q;
  assign wdt_rst_req = req_q;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import kwd_pkg::*;
#(
  parameter logic [7:0] OPEN_LAST = 8'hE1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_rdata,
  input logic       ctrl_open,
  input logic       wdt_flag,
  input logic       wdt_rst_req
);
  a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  a_r9_req_resets_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (wdt_flag && !ctrl_rdata[CTL_EN_BIT] && !ctrl_open));

  a_r8_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[CTL_EN_BIT] |=> !wdt_rst_req);

  a_r2_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_open) |-> $past(wr_en && wr_sel == SEL_KEY && wr_data == OPEN_LAST));

  a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_open |=> ($stable(ctrl_rdata) || wdt_rst_req));

  a_r10_flag_set_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_flag) |-> wdt_rst_req);

  a_r10_flag_clear_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_flag) |-> $past(wr_en && wr_sel == SEL_STAT && !wr_data[STAT_FLAG_BIT]));
endmodule

bind keyed_wdog keyed_wdog_chk #(.OPEN_LAST(KEY_B)) u_keyed_wdog_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .ctrl_rdata  (ctrl_rdata),
  .ctrl_open   (ctrl_open),
  .wdt_flag    (wdt_flag),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  localparam int CW = 9;
  localparam int BE = 2;
  localparam logic [1:0] S_CTRL = 2'd0, S_KEY = 2'd1, S_STAT = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_rdata;
  logic ctrl_open, wdt_flag, wdt_rst_req;

  int checks = 0, errors = 0, req_seen = 0, osc_half = 2, cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_wdog #(.CNT_W(CW), .BASE_EXP(BE)) i_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .ctrl_open(ctrl_open),
    .wdt_flag(wdt_flag), .wdt_rst_req(wdt_rst_req)
  );

  initial forever begin
    repeat (osc_half) @(negedge clk);
    osc = ~osc;
  end

  // behavioural reference model
  bit m_s0, m_s1, m_prev, m_en, m_open, m_armed, m_flag, m_req;
  int m_sel, m_cnt;

  always @(posedge clk or negedge rst_n) begin : model
    bit tick, kw, cw, sw, clr, hit;
    int lim;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_en = 0; m_open = 0; m_armed = 0;
      m_flag = 0; m_req = 0; m_sel = 0; m_cnt = 0;
    end else begin
      tick = m_s1 && !m_prev;
      kw = wr_en && wr_sel == S_KEY;
      cw = wr_en && wr_sel == S_CTRL && m_open;
      sw = wr_en && wr_sel == S_STAT;
      clr = cw && wr_data[5];
      lim = (1 << (BE + m_sel)) - 1;
      hit = tick && m_en && !clr && (m_cnt >= lim);
      if (hit) begin
        m_req = 1; m_en = 0; m_sel = 0; m_open = 0; m_armed = 0;
        m_cnt = 0; m_flag = 1;
      end else begin
        m_req = 0;
        if (!m_en || clr) m_cnt = 0;
        else if (tick) m_cnt = m_cnt + 1;
        if (kw) begin
          if (m_armed) begin
            m_armed = 0;
            if (!m_open && wr_data == 8'hE1) m_open = 1;
            else if (m_open && wr_data == 8'h1E) m_open = 0;
          end else begin
            m_armed = m_open ? (wr_data == 8'hE1) : (wr_data == 8'h1E);
          end
        end
        if (cw) begin
          m_en = wr_data[7];
          m_sel = int'(wr_data[2:0]);
        end
        if (sw && !wr_data[7]) m_flag = 0;
      end
      m_prev = m_s1; m_s1 = m_s0; m_s0 = osc;
    end
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (wdt_rst_req) req_seen++;
      chk(cur_req, "cycle compare {req,ctrl,open,flag}",
          int'({wdt_rst_req, ctrl_rdata, ctrl_open, wdt_flag}),
          int'({m_req, m_en, 4'b0, 3'(m_sel), m_open, m_flag}));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic unlock();
    wr(S_KEY, 8'h1E);
    wr(S_KEY, 8'hE1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog expired actual running expected finished", cur_req);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int r, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    cur_req = "R1";
    chk("R1", "ctrl after reset", int'(ctrl_rdata), 0);
    chk("R1", "open after reset", int'(ctrl_open), 0);
    chk("R1", "flag after reset", int'(wdt_flag), 0);
    chk("R1", "req after reset", int'(wdt_rst_req), 0);

    cur_req = "R2";
    wr(S_CTRL, 8'h87); idle(1);
    chk("R2", "locked ctrl write ignored", int'(ctrl_rdata), 0);
    unlock(); idle(1);
    chk("R2", "open after 1E,E1", int'(ctrl_open), 1);

    cur_req = "R5";
    wr(S_CTRL, 8'h3D); idle(1);
    chk("R5", "readback masks restart and unused bits", int'(ctrl_rdata), 8'h05);
    wr(S_CTRL, 8'hA2); idle(1);
    chk("R5", "enable bit 7 with select 2", int'(ctrl_rdata), 8'h82);
    wr(S_CTRL, 8'h02); idle(1);
    chk("R5", "enable cleared", int'(ctrl_rdata), 8'h02);

    cur_req = "R8";
    r = req_seen; idle(400);
    chk("R8", "no request while disabled", req_seen, r);

    cur_req = "R6";
    r = req_seen;
    wr(S_CTRL, 8'h80);
    t0 = cyc;
    while (req_seen == r && cyc - t0 < 100) idle(1);
    chk("R6", "select 0 timeout requested", req_seen, r + 1);
    chk("R6", "select 0 period within 4 ticks", int'((cyc - t0) >= 12 && (cyc - t0) <= 24), 1);

    cur_req = "R9";
    idle(1);
    chk("R9", "ctrl zero after timeout", int'(ctrl_rdata), 0);
    chk("R9", "locked after timeout", int'(ctrl_open), 0);
    chk("R9", "flag set", int'(wdt_flag), 1);
    wr(S_CTRL, 8'h80); idle(1);
    chk("R9", "relocked ctrl ignores write", int'(ctrl_rdata), 0);

    cur_req = "R7";
    unlock();
    wr(S_CTRL, 8'h81);
    r = req_seen;
    for (int i = 0; i < 10; i++) begin
      idle(16);
      wr(S_CTRL, 8'hA1);
    end
    chk("R7", "restarts prevent request", req_seen, r);
    idle(60);
    chk("R7", "request after restarts stop", req_seen, r + 1);

    cur_req = "R10";
    chk("R10", "flag kept through second watchdog reset", int'(wdt_flag), 1);
    wr(S_STAT, 8'h80); idle(1);
    chk("R10", "status write bit7=1 no effect", int'(wdt_flag), 1);
    wr(S_STAT, 8'h00); idle(1);
    chk("R10", "status write bit7=0 clears", int'(wdt_flag), 0);

    cur_req = "R3";
    unlock();
    wr(S_CTRL, 8'h03); idle(1);
    chk("R3", "write while open", int'(ctrl_rdata), 8'h03);
    wr(S_KEY, 8'hE1); wr(S_KEY, 8'h1E); idle(1);
    chk("R3", "locked after E1,1E", int'(ctrl_open), 0);
    wr(S_CTRL, 8'h07); idle(1);
    chk("R3", "ctrl unchanged after relock", int'(ctrl_rdata), 8'h03);

    cur_req = "R4";
    wr(S_KEY, 8'h1E); wr(S_KEY, 8'h55); wr(S_KEY, 8'hE1); idle(1);
    chk("R4", "1E,55,E1 stays locked", int'(ctrl_open), 0);
    wr(S_KEY, 8'h1E); wr(S_KEY, 8'h1E); wr(S_KEY, 8'hE1); idle(1);
    chk("R4", "1E,1E,E1 stays locked", int'(ctrl_open), 0);
    wr(S_KEY, 8'h1E); wr(S_STAT, 8'h80); wr(S_KEY, 8'hE1); idle(1);
    chk("R4", "status write between key bytes ignored", int'(ctrl_open), 1);
    wr(S_KEY, 8'hE1); wr(S_KEY, 8'h33); wr(S_KEY, 8'h1E); idle(1);
    chk("R4", "E1,33,1E stays open", int'(ctrl_open), 1);
    wr(S_KEY, 8'hE1); wr(S_KEY, 8'hE1); wr(S_KEY, 8'h1E); idle(1);
    chk("R4", "E1,E1,1E stays open", int'(ctrl_open), 1);

    cur_req = "R11";
    osc_half = 6;
    r = req_seen;
    wr(S_CTRL, 8'h82);
    idle(150);
    chk("R11", "no early request with long high phase", req_seen, r);
    idle(120);
    chk("R11", "one count per oscillator edge", req_seen, r + 1);

    cur_req = "R6";
    osc_half = 2;
    idle(20);
    unlock();
    wr(S_CTRL, 8'h87);
    r = req_seen;
    idle(1900);
    chk("R6", "select 7 not early", req_seen, r);
    idle(300);
    chk("R6", "select 7 timeout", req_seen, r + 1);

    cur_req = "R9";
    unlock();
    wr(S_CTRL, 8'h80);
    wr(S_KEY, 8'hE1); wr(S_KEY, 8'h1E);
    r = req_seen;
    idle(40);
    chk("R9", "timeout while locked", req_seen, r + 1);
    chk("R9", "ctrl zero after locked timeout", int'(ctrl_rdata), 0);

    cur_req = "R10";
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R10", "hardware reset clears flag", int'(wdt_flag), 0);
    chk("R1", "ctrl zero after hardware reset", int'(ctrl_rdata), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule